// File: doc/BRIEF.md
# Mixed-Sign Multiply-Accumulate Unit

This unit multiplies two 16-bit operands and folds the result into one of four 36-bit accumulators. It completes one operation per clock. Each operand is read as signed or unsigned according to a sign-mode code. The 32-bit product is widened to 36 bits before it reaches the accumulator: by sign extension when either operand is signed, and by zero extension when both are unsigned. The four extra bits above the product act as guard bits. They let a long run of accumulations grow before the value wraps.

The operation code picks one of four actions on the indexed accumulator: load it with the widened product, add the product to it, subtract the product from it, or leave it alone while still producing a product. Software-side access to the accumulators uses the same index, through a write port (a 32-bit value, sign-extended) and a clear strobe. The operand input follows a valid/ready handshake. `in_ready` is held high at all times, because every accepted operation retires in one cycle. A beat is therefore taken on every cycle in which `in_valid` is high, and the unit never applies back-pressure. The product and the selected accumulator appear on registered outputs one cycle after the operation.

Top module: `mac_unit`

## Requirements
- R1: After reset all four accumulators, `prod`, `acc_out` and `ovf` are zero, and `in_ready` is high both during and after reset.
- R2: With `sign_mode` 0, or the alias code 3, both operands are two's complement, and `prod` equals their signed 32-bit product in the cycle after the beat.
- R3: With `sign_mode` 1, `op_a` is signed and `op_b` is unsigned, and `prod` is their two's-complement 32-bit product.
- R4: With `sign_mode` 2, both operands are unsigned, `prod` is their unsigned 32-bit product, and the product is zero-extended to 36 bits before it is used.
- R5: `op_sel` 0 (load) writes the widened product into the accumulator chosen by `acc_idx`. The new value appears on `acc_out` in the cycle after the beat.
- R6: `op_sel` 1 (add) replaces the indexed accumulator with the accumulator plus the widened product, modulo 2^36.
- R7: `op_sel` 2 (subtract) replaces the indexed accumulator with the accumulator minus the widened product, modulo 2^36.
- R8: An add or subtract whose signed 36-bit result overflows wraps, and it sets `ovf`. `ovf` then stays set until a clear.
- R9: `wr_en` writes `wr_data` into the indexed accumulator, sign-extended from bit 31 to 36 bits.
- R10: `clr_en` zeroes the indexed accumulator and drops `ovf`.
- R11: In the same cycle, clear takes priority over write, and write takes priority over a valid operation. Only the indexed accumulator changes.
- R12: `op_sel` 3 updates `prod` and leaves every accumulator unchanged. Without `in_valid`, `prod` holds its value.
- R13: `acc_out` shows, one cycle later, the value that the accumulator indexed by `acc_idx` holds after that cycle's update. An idle cycle therefore reads any accumulator back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand beat valid |
| in_ready | output | 1 | Beat accepted; always high |
| op_a | input | 16 | First operand (the signed one in mode 1) |
| op_b | input | 16 | Second operand |
| sign_mode | input | 2 | 0 and 3 signed×signed, 1 signed×unsigned, 2 unsigned×unsigned |
| op_sel | input | 2 | 0 load, 1 add, 2 subtract, 3 product only |
| acc_idx | input | 2 | Accumulator selected for the operation, write, clear and readout |
| wr_en | input | 1 | Write `wr_data` into the indexed accumulator |
| wr_data | input | 32 | Write value, sign-extended |
| clr_en | input | 1 | Zero the indexed accumulator and drop `ovf` |
| prod | output | 32 | Registered product of the last beat |
| acc_out | output | 36 | Registered value of the indexed accumulator |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A table of operand pairs runs through every sign mode. It includes all-ones operands, the most negative value, and a large unsigned operand. The same bit pattern therefore yields different products and different 36-bit extensions, which exposes a mode that is decoded wrongly or an extension of the wrong kind. Directed sequences first build a known value with writes, then add and subtract both positive and negative products. They also drive a run of unsigned additions past the 36-bit signed limit, with the expected value checked after every step, so the cycle of the wrap and the sticking of the flag are both pinned down. Colliding clear, write and operation strobes, followed by reads of the other accumulators, separate the priority order from any disturbance of accumulators that were not selected.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    SM_SS     = 2'd0,
    SM_SU     = 2'd1,
    SM_UU     = 2'd2,
    SM_SS_ALT = 2'd3
  } sign_mode_e;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_NONE = 2'd3
  } op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult
  import mac_pkg::*;
#(
  parameter int OPW = 16
) (
  input  logic [OPW-1:0]   a,
  input  logic [OPW-1:0]   b,
  input  sign_mode_e       mode,
  output logic [2*OPW-1:0] product,
  output logic             product_signed
);
  localparam int XW = OPW + 1;
  localparam int FW = 2 * XW;

  logic           a_is_signed;
  logic           b_is_signed;
  logic signed [XW-1:0] a_x;
  logic signed [XW-1:0] b_x;
  logic signed [FW-1:0] full;

  always_comb begin
    a_is_signed    = (mode != SM_UU);
    b_is_signed    = (mode == SM_SS) || (mode == SM_SS_ALT);
    a_x            = {a_is_signed & a[OPW-1], a};
    b_x            = {b_is_signed & b[OPW-1], b};
    full           = FW'(a_x) * FW'(b_x);
    product        = full[2*OPW-1:0];
    product_signed = a_is_signed;
  end
endmodule

// File: rtl/mac_addsub.sv
module mac_addsub #(
  parameter int W = 36
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] operand,
  input  logic         subtract,
  output logic [W-1:0] result,
  output logic         overflow
);
  always_comb begin
    if (subtract) begin
      result   = acc - operand;
      overflow = (acc[W-1] != operand[W-1]) && (result[W-1] != acc[W-1]);
    end else begin
      result   = acc + operand;
      overflow = (acc[W-1] == operand[W-1]) && (result[W-1] != acc[W-1]);
    end
  end
endmodule

// File: rtl/mac_accbank.sv
module mac_accbank #(
  parameter int NACC = 4,
  parameter int ACCW = 36
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_en,
  input  logic [$clog2(NACC)-1:0] upd_idx,
  input  logic [ACCW-1:0]         upd_val,
  output logic [ACCW-1:0]         acc_q [NACC]
);
  localparam int IDXW = $clog2(NACC);

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    logic [ACCW-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else if (upd_en && (upd_idx == IDXW'(g))) begin
        r <= upd_val;
      end
    end
    assign acc_q[g] = r;
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 36,
  parameter int NACC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [OPW-1:0]          op_a,
  input  logic [OPW-1:0]          op_b,
  input  logic [1:0]              sign_mode,
  input  logic [1:0]              op_sel,
  input  logic [$clog2(NACC)-1:0] acc_idx,
  input  logic                    wr_en,
  input  logic [2*OPW-1:0]        wr_data,
  input  logic                    clr_en,
  output logic [2*OPW-1:0]        prod,
  output logic [ACCW-1:0]         acc_out,
  output logic                    ovf
);
  localparam int PW   = 2 * OPW;
  localparam int GW   = ACCW - PW;

  op_e             op;
  logic [PW-1:0]   prod_w;
  logic            prod_is_signed;
  logic [ACCW-1:0] prod_ext;
  logic [ACCW-1:0] wr_ext;
  logic [ACCW-1:0] acc_arr [NACC];
  logic [ACCW-1:0] sel_acc;
  logic [ACCW-1:0] sum_w;
  logic            sum_ovf;
  logic            arith;
  logic            upd_en;
  logic [ACCW-1:0] nxt;
  logic [PW-1:0]   prod_q;
  logic [ACCW-1:0] acc_out_q;
  logic            ovf_q;

  assign in_ready = 1'b1;
  assign op       = op_e'(op_sel);

  mac_mult #(.OPW(OPW)) u_mult (
    .a              (op_a),
    .b              (op_b),
    .mode           (sign_mode_e'(sign_mode)),
    .product        (prod_w),
    .product_signed (prod_is_signed)
  );

  assign prod_ext = {{GW{prod_is_signed & prod_w[PW-1]}}, prod_w};
  assign wr_ext   = {{GW{wr_data[PW-1]}}, wr_data};
  assign sel_acc  = acc_arr[acc_idx];

  mac_addsub #(.W(ACCW)) u_addsub (
    .acc      (sel_acc),
    .operand  (prod_ext),
    .subtract (op == OP_SUB),
    .result   (sum_w),
    .overflow (sum_ovf)
  );

  assign arith = in_valid && ((op == OP_ADD) || (op == OP_SUB));

  always_comb begin
    upd_en = 1'b1;
    if (clr_en) begin
      nxt = '0;
    end else if (wr_en) begin
      nxt = wr_ext;
    end else if (in_valid && (op == OP_LOAD)) begin
      nxt = prod_ext;
    end else if (arith) begin
      nxt = sum_w;
    end else begin
      nxt    = sel_acc;
      upd_en = 1'b0;
    end
  end

  mac_accbank #(.NACC(NACC), .ACCW(ACCW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (upd_en),
    .upd_idx (acc_idx),
    .upd_val (nxt),
    .acc_q   (acc_arr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q    <= '0;
      acc_out_q <= '0;
      ovf_q     <= 1'b0;
    end else begin
      if (in_valid) prod_q <= prod_w;
      acc_out_q <= nxt;
      if (clr_en) begin
        ovf_q <= 1'b0;
      end else if (arith && !wr_en && sum_ovf) begin
        ovf_q <= 1'b1;
      end
    end
  end

  assign prod    = prod_q;
  assign acc_out = acc_out_q;
  assign ovf     = ovf_q;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int OPW  = 16,
  parameter int ACCW = 36,
  parameter int NACC = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [OPW-1:0]          op_a,
  input logic [OPW-1:0]          op_b,
  input logic [1:0]              sign_mode,
  input logic [1:0]              op_sel,
  input logic [$clog2(NACC)-1:0] acc_idx,
  input logic                    wr_en,
  input logic [2*OPW-1:0]        wr_data,
  input logic                    clr_en,
  input logic [2*OPW-1:0]        prod,
  input logic [ACCW-1:0]         acc_out,
  input logic                    ovf
);
  localparam int PW = 2 * OPW;
  localparam int GW = ACCW - PW;

  logic seen_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_rst <= 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n && seen_rst) begin
      a_r1_reset_clear : assert (acc_out == '0 && prod == '0 && !ovf && in_ready);
    end
  end

  a_r2_signed_product : assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (sign_mode == 2'd0)
    |=> $signed(prod) == ($signed($past(op_a)) * $signed($past(op_b))));

  a_r4_unsigned_product : assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (sign_mode == 2'd2)
    |=> prod == (PW'($past(op_a)) * PW'($past(op_b))));

  a_r8_ovf_sticky : assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr_en |=> ovf);

  a_r9_write_sext : assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !clr_en
    |=> acc_out == {{GW{$past(wr_data[PW-1])}}, $past(wr_data)});

  a_r10_clear_zero : assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (acc_out == '0) && !ovf);

  a_r12_prod_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(prod));
endmodule

bind mac_unit mac_unit_chk #(.OPW(OPW), .ACCW(ACCW), .NACC(NACC)) u_chk (.*);

// File: tb/mac_unit_test.sv
`timescale 1ns/1ps
module mac_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] op_a = '0, op_b = '0;
  logic [1:0]  sign_mode = '0, op_sel = '0, acc_idx = '0;
  logic        wr_en = 1'b0, clr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] prod;
  logic [35:0] acc_out;
  logic        ovf;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [35:0] mdl [4];

  always #4 clk = ~clk;

  mac_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .sign_mode(sign_mode), .op_sel(op_sel),
    .acc_idx(acc_idx), .wr_en(wr_en), .wr_data(wr_data), .clr_en(clr_en),
    .prod(prod), .acc_out(acc_out), .ovf(ovf)
  );

  // entry: mode, a, b, expected product, expected widened accumulator
  localparam logic [101:0] VEC [10] = '{
    {2'd0, 16'h0003, 16'h0005, 32'h0000000F, 36'h00000000F},
    {2'd0, 16'hFFFF, 16'hFFFF, 32'h00000001, 36'h000000001},
    {2'd0, 16'hFFFE, 16'h0003, 32'hFFFFFFFA, 36'hFFFFFFFFA},
    {2'd0, 16'h8000, 16'h8000, 32'h40000000, 36'h040000000},
    {2'd1, 16'hFFFF, 16'hFFFF, 32'hFFFF0001, 36'hFFFFF0001},
    {2'd1, 16'h0002, 16'h8000, 32'h00010000, 36'h000010000},
    {2'd1, 16'h8000, 16'hFFFF, 32'h80008000, 36'hF80008000},
    {2'd2, 16'hFFFF, 16'hFFFF, 32'hFFFE0001, 36'h0FFFE0001},
    {2'd2, 16'h8000, 16'h0002, 32'h00010000, 36'h000010000},
    {2'd3, 16'hFFFF, 16'hFFFF, 32'h00000001, 36'h000000001}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] m, input logic [1:0] o,
                       input logic [1:0] i, input logic [15:0] a, input logic [15:0] b,
                       input logic w, input logic [31:0] wd, input logic c);
    in_valid = v; sign_mode = m; op_sel = o; acc_idx = i;
    op_a = a; op_b = b; wr_en = w; wr_data = wd; clr_en = c;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; wr_en = 1'b0; clr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] i);
    drive(1'b0, 2'd0, 2'd3, i, 16'h0, 16'h0, 1'b0, 32'h0, 1'b0);
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd1:    return "R3 signed x unsigned";
      2'd2:    return "R4 unsigned x unsigned";
      default: return "R2 signed x signed";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [35:0] m, s;
    logic        exp_ovf;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 acc_out in reset", acc_out, 0);
    chk("R1 prod in reset", prod, 0);
    chk("R1 ovf in reset", ovf, 0);
    chk("R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rd(2'(i));
      chk("R1 accumulator zero after reset", acc_out, 0);
      mdl[i] = '0;
    end
    chk("R1 in_ready after reset", in_ready, 1);

    // R5 with R2/R3/R4: table of loads
    for (int i = 0; i < 10; i++) begin
      drive(1'b1, VEC[i][101:100], 2'd0, 2'(i % 4), VEC[i][99:84], VEC[i][83:68],
            1'b0, 32'h0, 1'b0);
      chk({mode_tag(VEC[i][101:100]), " product"}, prod, VEC[i][67:36]);
      chk("R5 load widened product", acc_out, VEC[i][35:0]);
      mdl[i % 4] = VEC[i][35:0];
    end

    // R12: product-only op and idle hold
    drive(1'b1, 2'd0, 2'd3, 2'd0, 16'h0002, 16'h0003, 1'b0, 32'h0, 1'b0);
    chk("R12 product-only prod", prod, 6);
    chk("R12 product-only leaves accumulator", acc_out, mdl[0]);
    op_a = 16'h1234; op_b = 16'h5678;
    @(posedge clk); @(negedge clk);
    chk("R12 prod holds without valid", prod, 6);

    // R9 / R6 / R7
    drive(1'b0, 2'd0, 2'd0, 2'd1, 16'h0, 16'h0, 1'b1, 32'd100, 1'b0);
    chk("R9 write positive", acc_out, 100);
    drive(1'b1, 2'd0, 2'd1, 2'd1, 16'd10, 16'd10, 1'b0, 32'h0, 1'b0);
    chk("R6 add", acc_out, 200);
    drive(1'b1, 2'd0, 2'd2, 2'd1, 16'd3, 16'd50, 1'b0, 32'h0, 1'b0);
    chk("R7 subtract", acc_out, 50);
    drive(1'b1, 2'd0, 2'd2, 2'd1, 16'hFFFF, 16'd1, 1'b0, 32'h0, 1'b0);
    chk("R7 subtract negative product", acc_out, 51);
    mdl[1] = 36'd51;
    drive(1'b0, 2'd0, 2'd0, 2'd2, 16'h0, 16'h0, 1'b1, 32'h80000000, 1'b0);
    chk("R9 write sign-extends", acc_out, 36'hF80000000);

    // R11: priority and isolation
    drive(1'b1, 2'd0, 2'd0, 2'd2, 16'd7, 16'd7, 1'b1, 32'd9, 1'b1);
    chk("R11 clear beats write and op", acc_out, 0);
    drive(1'b1, 2'd0, 2'd0, 2'd2, 16'd7, 16'd7, 1'b1, 32'd5, 1'b0);
    chk("R11 write beats op", acc_out, 5);
    rd(2'd0);
    chk("R11 R13 acc0 untouched", acc_out, mdl[0]);
    rd(2'd1);
    chk("R11 R13 acc1 untouched", acc_out, mdl[1]);

    // R8: wrap and sticky flag
    drive(1'b0, 2'd0, 2'd0, 2'd3, 16'h0, 16'h0, 1'b1, 32'h7FFFFFFF, 1'b0);
    m = 36'h07FFFFFFF;
    exp_ovf = 1'b0;
    for (int k = 0; k < 9; k++) begin
      drive(1'b1, 2'd2, 2'd1, 2'd3, 16'hFFFF, 16'hFFFF, 1'b0, 32'h0, 1'b0);
      s = m + 36'h0FFFE0001;
      if (!m[35] && s[35]) exp_ovf = 1'b1;
      m = s;
      chk("R8 accumulate wraps", acc_out, m);
      chk("R8 overflow flag", ovf, exp_ovf);
    end
    chk("R8 overflow reached", exp_ovf, 1);
    drive(1'b1, 2'd0, 2'd2, 2'd3, 16'd1, 16'd1, 1'b0, 32'h0, 1'b0);
    m = m - 36'd1;
    chk("R8 wrapped subtract", acc_out, m);
    chk("R8 flag sticky", ovf, 1);

    // R10: clear
    drive(1'b0, 2'd0, 2'd0, 2'd3, 16'h0, 16'h0, 1'b0, 32'h0, 1'b1);
    chk("R10 clear zeroes", acc_out, 0);
    chk("R10 clear drops flag", ovf, 0);
    rd(2'd2);
    chk("R10 R13 other accumulator kept", acc_out, 5);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule